// File: doc/BRIEF.md
# Condition Register Bit-Logic Unit

This block is a purely combinational execution unit for a condition register built from eight 4-bit fields (32 bits in all). In its bit-logic mode it fetches two individual condition bits, combines them with one of eight Boolean functions, and places the result into a single destination bit. The other three bits of the destination field are carried over from their current values. In its field-copy mode it moves one whole 4-bit field to another field.

The unit does not hold the register itself. The current register contents come in on `cr_i`. The unit reports which fields it reads and writes on one-hot per-field strobes. It drives a 32-bit write word in which the 4-bit result field appears in every field slot, so the register file can take the slot named by the write strobe. Numbering runs from the most significant end: field 0 and bit 0 are the leftmost. A kill input suppresses all write strobes when an instruction must not retire.

Top module: `cr_logic_unit`

## Requirements
- R1: Bit index i addresses `cr_i[31-i]`. Field f occupies `cr_i[31-4f -: 4]`. Field f is signalled on strobe bit `7-f` of both `rd_stb_o` and `wr_stb_o`.
- R2: In a bit-logic operation, each 5-bit index splits into a field number (bits 4:2) and a position within that field (bits 1:0). Position 0 is the field's most significant bit.
- R3: Operation codes 0 to 7 give the result a&b, a|b, ~(a&b), a^b, ~(a|b), a&~b, ~(a^b) and a|~b respectively. Here a is the bit named by `src_a_i` and b is the bit named by `src_b_i`.
- R4: For a bit-logic operation, the written field equals the old destination field with only the addressed bit replaced by the result.
- R5: For a bit-logic operation, `rd_stb_o` holds exactly the strobes of the fields containing the two source bits. When both sources fall in one field, that field's strobe is the only one raised.
- R6: For a bit-logic operation without kill, `wr_stb_o` has exactly one bit set, the one for the destination field.
- R7: Operation code 8 copies field `src_a_i[2:0]` to field `dst_i[2:0]`. It raises only the source field's read strobe and only the destination field's write strobe, writes the source field's value, and ignores `src_b_i`.
- R8: `wr_data_o` is the 4-bit result field repeated in all eight field slots.
- R9: While `kill_i` is 1, `wr_stb_o` is zero. `rd_stb_o` and `wr_data_o` are the same as with `kill_i` at 0.
- R10: Operation codes 9 to 15 drive `rd_stb_o`, `wr_stb_o` and `wr_data_o` to zero.
- R11: When a source field is also the destination field, that field has both its read strobe and its write strobe raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0-7 bit logic, 8 field copy, others invalid) |
| src_a_i | input | 5 | First source bit index, or source field index in bits 2:0 for a copy |
| src_b_i | input | 5 | Second source bit index |
| dst_i | input | 5 | Destination bit index, or destination field index in bits 2:0 for a copy |
| cr_i | input | 32 | Current condition register contents |
| kill_i | input | 1 | Suppresses all write strobes |
| rd_stb_o | output | 8 | One-hot-per-field read strobes, bit 7 is field 0 |
| wr_stb_o | output | 8 | Per-field write strobe, bit 7 is field 0 |
| wr_data_o | output | 32 | Result field replicated into every field slot |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with no register delay. The bench applies each input vector, waits a fixed settle delay of 1 ns (well inside the 4 ns period), and only then compares all three outputs with values it derives from bit-reversed indexing of its own. All bit-logic operations are swept over every combination of source and destination index with fresh register contents each time. Field copy is swept over all source and destination field pairs. The invalid codes and the kill input are then applied to the same vectors.

// File: rtl/cr_logic_pkg.sv
package cr_logic_pkg;

  // Operation codes; 0..7 are the bit-logic family, 8 copies a field.
  typedef enum logic [3:0] {
    CROP_AND   = 4'd0,
    CROP_OR    = 4'd1,
    CROP_NAND  = 4'd2,
    CROP_XOR   = 4'd3,
    CROP_NOR   = 4'd4,
    CROP_ANDC  = 4'd5,
    CROP_EQV   = 4'd6,
    CROP_ORC   = 4'd7,
    CROP_FCOPY = 4'd8
  } cr_op_e;

  // True for the eight single-bit Boolean operations.
  function automatic logic op_is_bitlogic(input logic [3:0] op);
    return (op[3] == 1'b0);
  endfunction

  // True for the whole-field copy.
  function automatic logic op_is_copy(input logic [3:0] op);
    return (op == CROP_FCOPY);
  endfunction

  // Boolean function of two condition bits.
  function automatic logic bool_apply(input logic [2:0] sel, input logic a, input logic b);
    logic r;
    case (sel)
      3'd0:    r = a & b;
      3'd1:    r = a | b;
      3'd2:    r = ~(a & b);
      3'd3:    r = a ^ b;
      3'd4:    r = ~(a | b);
      3'd5:    r = a & ~b;
      3'd6:    r = ~(a ^ b);
      default: r = a | ~b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cr_field_pick.sv
// Selects one field of the register (field 0 = most significant) and
// produces the matching one-hot strobe (field 0 = strobe MSB).
module cr_field_pick #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int FSEL_W    = $clog2(NUM_FIELDS)
) (
  input  logic [CR_W-1:0]       cr_i,
  input  logic [FSEL_W-1:0]     fsel_i,
  output logic [FIELD_W-1:0]    field_o,
  output logic [NUM_FIELDS-1:0] stb_o
);

  logic [FIELD_W-1:0] slice [NUM_FIELDS];

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_slice
    assign slice[f] = cr_i[CR_W-1-f*FIELD_W -: FIELD_W];
    assign stb_o[NUM_FIELDS-1-f] = (fsel_i == FSEL_W'(f));
  end

  always_comb begin
    field_o = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (fsel_i == FSEL_W'(f)) field_o = slice[f];
    end
  end

endmodule

// File: rtl/cr_bit_from_field.sv
// Picks one bit out of a field; position 0 is the field's MSB.
module cr_bit_from_field #(
  parameter int FIELD_W  = 4,
  localparam int POS_W   = $clog2(FIELD_W)
) (
  input  logic [FIELD_W-1:0] field_i,
  input  logic [POS_W-1:0]   pos_i,
  output logic               bit_o
);

  logic [POS_W-1:0] lsb_pos;

  assign lsb_pos = POS_W'(FIELD_W-1) - pos_i;
  assign bit_o   = field_i[lsb_pos];

endmodule

// File: rtl/cr_field_merge.sv
// Replaces the addressed bit of a field (position 0 = MSB) and keeps the rest.
module cr_field_merge #(
  parameter int FIELD_W  = 4,
  localparam int POS_W   = $clog2(FIELD_W)
) (
  input  logic [FIELD_W-1:0] old_i,
  input  logic [POS_W-1:0]   pos_i,
  input  logic               bit_i,
  output logic [FIELD_W-1:0] new_o
);

  for (genvar p = 0; p < FIELD_W; p++) begin : g_bit
    assign new_o[FIELD_W-1-p] = (pos_i == POS_W'(p)) ? bit_i : old_i[FIELD_W-1-p];
  end

endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int FSEL_W    = $clog2(NUM_FIELDS),
  localparam int POS_W     = $clog2(FIELD_W),
  localparam int IDX_W     = FSEL_W + POS_W
) (
  input  logic [3:0]            op_i,
  input  logic [IDX_W-1:0]      src_a_i,
  input  logic [IDX_W-1:0]      src_b_i,
  input  logic [IDX_W-1:0]      dst_i,
  input  logic [CR_W-1:0]       cr_i,
  input  logic                  kill_i,
  output logic [NUM_FIELDS-1:0] rd_stb_o,
  output logic [NUM_FIELDS-1:0] wr_stb_o,
  output logic [CR_W-1:0]       wr_data_o
);
  import cr_logic_pkg::*;

  // Decode events, named for the checker.
  logic is_bit_op, is_copy, op_valid, wr_enable;
  assign is_bit_op = op_is_bitlogic(op_i);
  assign is_copy   = op_is_copy(op_i);
  assign op_valid  = is_bit_op | is_copy;
  assign wr_enable = op_valid & ~kill_i;

  // Field selection: bit ops take the upper index bits, copy takes the low ones.
  logic [FSEL_W-1:0] fsel_a, fsel_b, fsel_d;
  logic [POS_W-1:0]  pos_a, pos_b, pos_d;
  assign fsel_a = is_copy ? src_a_i[FSEL_W-1:0] : src_a_i[IDX_W-1:POS_W];
  assign fsel_d = is_copy ? dst_i[FSEL_W-1:0]   : dst_i[IDX_W-1:POS_W];
  assign fsel_b = src_b_i[IDX_W-1:POS_W];
  assign pos_a  = src_a_i[POS_W-1:0];
  assign pos_b  = src_b_i[POS_W-1:0];
  assign pos_d  = dst_i[POS_W-1:0];

  logic [FIELD_W-1:0]    field_a, field_b, field_d;
  logic [NUM_FIELDS-1:0] stb_a, stb_b, stb_d;

  cr_field_pick #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_pick_a (
    .cr_i(cr_i), .fsel_i(fsel_a), .field_o(field_a), .stb_o(stb_a));
  cr_field_pick #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_pick_b (
    .cr_i(cr_i), .fsel_i(fsel_b), .field_o(field_b), .stb_o(stb_b));
  cr_field_pick #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_pick_d (
    .cr_i(cr_i), .fsel_i(fsel_d), .field_o(field_d), .stb_o(stb_d));

  logic bit_a, bit_b, bit_res;

  cr_bit_from_field #(.FIELD_W(FIELD_W)) u_bit_a (
    .field_i(field_a), .pos_i(pos_a), .bit_o(bit_a));
  cr_bit_from_field #(.FIELD_W(FIELD_W)) u_bit_b (
    .field_i(field_b), .pos_i(pos_b), .bit_o(bit_b));

  assign bit_res = bool_apply(op_i[2:0], bit_a, bit_b);

  logic [FIELD_W-1:0] merged_field, result_field;

  cr_field_merge #(.FIELD_W(FIELD_W)) u_merge (
    .old_i(field_d), .pos_i(pos_d), .bit_i(bit_res), .new_o(merged_field));

  assign result_field = is_copy ? field_a : merged_field;

  // Outputs.
  assign rd_stb_o = is_bit_op ? (stb_a | stb_b) :
                    is_copy   ? stb_a : '0;
  assign wr_stb_o = wr_enable ? stb_d : '0;

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_repl
    assign wr_data_o[k*FIELD_W +: FIELD_W] = op_valid ? result_field : '0;
  end

endmodule

// File: rtl/cr_logic_unit_chk.sv
module cr_logic_unit_chk #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int FSEL_W    = $clog2(NUM_FIELDS),
  localparam int POS_W     = $clog2(FIELD_W),
  localparam int IDX_W     = FSEL_W + POS_W
) (
  input logic [3:0]            op_i,
  input logic [IDX_W-1:0]      src_a_i,
  input logic [IDX_W-1:0]      src_b_i,
  input logic [IDX_W-1:0]      dst_i,
  input logic                  kill_i,
  input logic [NUM_FIELDS-1:0] rd_stb_o,
  input logic [NUM_FIELDS-1:0] wr_stb_o,
  input logic [CR_W-1:0]       wr_data_o
);

  always_comb begin
    // R6
    wr_onehot_chk: assert ($onehot0(wr_stb_o));
    // R9
    if (kill_i) kill_no_write_chk: assert (wr_stb_o == '0);
    // R6
    if (!kill_i && !op_i[3])
      bitop_single_write_chk: assert ($countones(wr_stb_o) == 1 &&
        wr_stb_o[NUM_FIELDS-1-int'(dst_i[IDX_W-1:POS_W])]);
    // R5
    if (!op_i[3])
      bitop_reads_sources_chk: assert (rd_stb_o[NUM_FIELDS-1-int'(src_a_i[IDX_W-1:POS_W])] &&
        rd_stb_o[NUM_FIELDS-1-int'(src_b_i[IDX_W-1:POS_W])] && $countones(rd_stb_o) <= 2);
    // R7
    if (op_i == 4'd8)
      copy_single_read_chk: assert ($countones(rd_stb_o) == 1 &&
        rd_stb_o[NUM_FIELDS-1-int'(src_a_i[FSEL_W-1:0])]);
    // R10
    if (op_i > 4'd8)
      invalid_idle_chk: assert (rd_stb_o == '0 && wr_stb_o == '0 && wr_data_o == '0);
    // R8
    for (int k = 1; k < NUM_FIELDS; k++)
      repl_slot_chk: assert (wr_data_o[k*FIELD_W +: FIELD_W] == wr_data_o[FIELD_W-1:0]);
  end

endmodule

bind cr_logic_unit cr_logic_unit_chk #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_chk (
  .op_i(op_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i), .kill_i(kill_i),
  .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .wr_data_o(wr_data_o));

// File: tb/cr_logic_unit_test.sv
`timescale 1ns/1ps
module cr_logic_unit_test;

  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [4:0]  sa, sb, sd;
  logic [31:0] cr;
  logic        kill;
  logic [7:0]  rd_stb, wr_stb;
  logic [31:0] wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cr_logic_unit uut (
    .op_i(op), .src_a_i(sa), .src_b_i(sb), .dst_i(sd), .cr_i(cr), .kill_i(kill),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .wr_data_o(wr_data));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference: bit i of the register is cr[31-i].
  function automatic logic ref_bool(input int code, input logic a, input logic b);
    case (code)
      0: return a && b;
      1: return a || b;
      2: return !(a && b);
      3: return a != b;
      4: return !(a || b);
      5: return a && !b;
      6: return a == b;
      default: return a || !b;
    endcase
  endfunction

  function automatic logic [31:0] spread(input logic [3:0] f);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) w = (w << 4) | 32'(f);
    return w;
  endfunction

  task automatic apply(input int o, input int a, input int b, input int d,
                       input logic [31:0] c, input logic k);
    op = 4'(o); sa = 5'(a); sb = 5'(b); sd = 5'(d); cr = c; kill = k;
    #1;
  endtask

  // Bit-logic vector with full comparison.
  task automatic bit_vec(input int o, input int a, input int b, input int d,
                         input logic [31:0] c, input logic k);
    logic [31:0] nxt;
    logic        res;
    logic [3:0]  fld;
    res = ref_bool(o, c[31-a], c[31-b]);
    nxt = c;
    nxt[31-d] = res;
    fld = nxt[31-4*(d/4) -: 4];
    apply(o, a, b, d, c, k);
    // R3 R4 R8: merged, replicated result
    check("R4", "wr_data", wr_data, spread(fld));
    // R5 R11: read strobes
    check("R5", "rd_stb", {24'd0, rd_stb},
          32'((8'h80 >> (a/4)) | (8'h80 >> (b/4))));
    // R6 R9 R11: write strobe
    check(k ? "R9" : "R6", "wr_stb", {24'd0, wr_stb},
          k ? 32'd0 : 32'(8'h80 >> (d/4)));
  endtask

  initial begin
    op = 4'd15; sa = '0; sb = '0; sd = '0; cr = '0; kill = 1'b0;
    #3;
    // R10: idle state on an invalid code
    check("R10", "idle rd_stb", {24'd0, rd_stb}, 32'd0);
    check("R10", "idle wr_data", wr_data, 32'd0);

    // R1 R2: field 0 bit 0 is the register MSB
    bit_vec(1, 0, 0, 31, 32'h8000_0000, 1'b0);
    check("R1", "bit31 set from bit0", wr_data, 32'h1111_1111);
    // R2: position 1 of field 2
    bit_vec(0, 9, 9, 4, 32'h0040_0000, 1'b0);
    check("R2", "field2 pos1 to field1 pos0", wr_data, 32'h8888_8888);
    // R11: source and destination in the same field
    bit_vec(3, 12, 13, 14, 32'h000A_0000 | 32'h0000_0000, 1'b0);
    check("R11", "same field rd", {24'd0, rd_stb}, 32'h10);
    check("R11", "same field wr", {24'd0, wr_stb}, 32'h10);

    // R3 R4 R5 R6 R8: exhaustive sweep of bit-logic operations
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          for (int d = 0; d < 32; d++)
            bit_vec(o, a, b, d, $urandom, 1'b0);

    // R9: kill leaves reads and data, clears writes
    for (int i = 0; i < 200; i++)
      bit_vec(i % 8, $urandom_range(31), $urandom_range(31), $urandom_range(31), $urandom, 1'b1);

    // R7: field copy over all pairs, src_b ignored
    for (int s = 0; s < 8; s++)
      for (int d = 0; d < 8; d++) begin
        logic [31:0] c = $urandom;
        apply(8, s, $urandom_range(31), d, c, 1'b0);
        check("R7", "copy data", wr_data, spread(c[31-4*s -: 4]));
        check("R7", "copy rd_stb", {24'd0, rd_stb}, 32'(8'h80 >> s));
        check("R7", "copy wr_stb", {24'd0, wr_stb}, 32'(8'h80 >> d));
        apply(8, s, 0, d, c, 1'b1);
        check("R9", "copy kill wr_stb", {24'd0, wr_stb}, 32'd0);
        check("R9", "copy kill data", wr_data, spread(c[31-4*s -: 4]));
      end

    // R10: every invalid code
    for (int o = 9; o < 16; o++) begin
      apply(o, $urandom_range(31), $urandom_range(31), $urandom_range(31), $urandom, 1'b0);
      check("R10", "invalid rd_stb", {24'd0, rd_stb}, 32'd0);
      check("R10", "invalid wr_stb", {24'd0, wr_stb}, 32'd0);
      check("R10", "invalid wr_data", wr_data, 32'd0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #700000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule